// File: doc/BRIEF.md
# Dynamic 16/32-bit Bus Width Sequencer

This block drives a processor's local memory bus. It takes one 32-bit request at a time over a valid/ready handshake and runs it as one or two bus cycles on a shared address/data bus. A full-width port answers in a single data cycle. A half-width port gets a second data cycle to its odd word. The requester can ask for a plain read, a plain write, or an indivisible read-modify-write. When the last bus cycle ends, the block returns the 32-bit read result with a one-cycle completion pulse.

Every bus cycle starts with an address cycle. During it the address strobe is high and the four low bus lines carry a cycle-type code. The strobe falls as the block moves into the data cycle. At the end of each data cycle the block samples a width input from the addressed port. On the even word this input tells the block whether the port is narrow. On the odd word it tells the block which half of the bus the port is wired to. On the odd word the block exchanges the two strobe pairs and the two 16-bit data halves. This lets a narrow port use only the strobes and lanes of its own half. A page-mode input lets the second word skip its address cycle. A fault input throws away the partial access and starts it again.

Top module: `bus_width_seq`

## Requirements
- R1: While the address strobe is high, lad_out[3:0] carries the cycle code 4'b1100 for a read-modify-write and 4'b1000 for any other access. lad_out[4] carries the word select: 0 for the even word and 1 for the odd word. The other address lines carry the request address.
- R2: If port16_n is high at the end of the even-word data cycle, the access is a single data cycle over all 32 lanes (for a read-modify-write, a single cycle per phase).
- R3: If port16_n is low at the end of the even-word data cycle, an odd-word data cycle always follows. This holds even when the byte enables select only one half.
- R4: At the end of the odd-word data cycle, port16_n low means the port uses lanes [15:0] and port16_n high means it uses lanes [31:16]. A lower port returns bits [15:0] first and bits [31:16] second. An upper port returns bits [31:16] first and bits [15:0] second. The lanes of the unused half are ignored.
- R5: In the even-word cycle, col_stb equals the byte enables and write data goes out unswapped. In the odd-word cycle, col_stb equals {be[1:0], be[3:2]} and the write data goes out as {wdata[15:0], wdata[31:16]}.
- R6: If page_ok_n is low at the end of the even-word data cycle, the odd-word data cycle follows with no address cycle. Otherwise a new address cycle comes first.
- R7: A read-modify-write runs a read phase and then a write phase, and returns the value read before the write. On a half-width page-mode port it takes one address cycle and four data cycles. On a full-width port it takes one address cycle and two data cycles.
- R8: If bus_fault is high at the end of a data cycle, the block goes back to an even-word address cycle and repeats the whole access. No completion pulse is given for the aborted attempt, and rsp_rdata stays zero until completion.
- R9: req_ready is high only while idle. rsp_done is a single-cycle pulse in the clock after the last data cycle, and rsp_rdata is valid during that pulse.
- R10: After reset, req_ready is 1 and addr_strobe, col_stb and rsp_done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted (idle) |
| req_addr | input | DATA_W | Request address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_rmw | input | 1 | Read-modify-write request |
| req_be | input | LANES | Byte enables |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | Completion pulse |
| rsp_rdata | output | DATA_W | Assembled read data |
| addr_strobe | output | 1 | Address latch strobe; the data cycle begins when it falls |
| col_stb | output | LANES | Byte-lane column strobes, active high |
| lad_out | output | DATA_W | Address/status and write data driven onto the bus |
| lad_oe | output | 1 | Bus drive enable |
| lad_in | input | DATA_W | Bus read data |
| port16_n | input | 1 | Port width / half select |
| page_ok_n | input | 1 | Port accepts a page-mode second access (low) |
| bus_fault | input | 1 | Bus fault for the current data cycle |

## Verification
The bench builds the block with its default DATA_W of 32 and WORD_BIT of 4. At these values the four strobe lanes split into two swappable pairs, and the cycle code sits just below the word-select line. The bench's bus model can then act as a full-width port, a lower-half port or an upper-half port. It fills the unused half with a marker pattern. This puts within reach the lane swap, the word ordering for both halves, the page-mode and non-page-mode cycle counts, both read-modify-write lengths, and a fault on the odd word.

// File: rtl/bws_pkg.sv
package bws_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } bws_state_e;

    localparam int STAT_W = 4;
    localparam logic [STAT_W-1:0] CODE_PLAIN  = 4'b1000;
    localparam logic [STAT_W-1:0] CODE_LOCKED = 4'b1100;
endpackage

// File: rtl/bws_lane_swap.sv
module bws_lane_swap #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    input  logic         swap,
    output logic [W-1:0] dout
);
    localparam int HALF = W / 2;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = swap ? din[(i + HALF) % W] : din[i];
    end
endmodule

// File: rtl/bws_read_merge.sv
module bws_read_merge #(
    parameter int W = 32
) (
    input  logic [W-1:0] held,
    input  logic [W-1:0] bus,
    input  logic         odd,
    input  logic         upper,
    output logic [W-1:0] merged
);
    localparam int HALF = W / 2;

    always_comb begin
        if (!odd) begin
            merged = bus;
        end else if (upper) begin
            merged = {held[W-1:HALF], bus[W-1:HALF]};
        end else begin
            merged = {bus[HALF-1:0], held[HALF-1:0]};
        end
    end
endmodule

// File: rtl/bws_status_enc.sv
module bws_status_enc
    import bws_pkg::*;
(
    input  logic              locked,
    output logic [STAT_W-1:0] code
);
    always_comb begin
        code = locked ? CODE_LOCKED : CODE_PLAIN;
    end
endmodule

// File: rtl/bus_width_seq.sv
module bus_width_seq
    import bws_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int WORD_BIT = 4,
    localparam int LANES   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DATA_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_rmw,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              addr_strobe,
    output logic [LANES-1:0]  col_stb,
    output logic [DATA_W-1:0] lad_out,
    output logic              lad_oe,
    input  logic [DATA_W-1:0] lad_in,
    input  logic              port16_n,
    input  logic              page_ok_n,
    input  logic              bus_fault
);
    typedef struct packed {
        bws_state_e        state;
        logic              odd;
        logic              wr_phase;
        logic              page;
        logic              rmw;
        logic              write;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } regs_t;

    localparam regs_t REGS_RESET = '{
        state:    ST_IDLE,
        odd:      1'b0,
        wr_phase: 1'b0,
        page:     1'b0,
        rmw:      1'b0,
        write:    1'b0,
        addr:     '0,
        wdata:    '0,
        be:       '0,
        rdata:    '0,
        done:     1'b0
    };

    regs_t r_q, r_d;

    logic [STAT_W-1:0] status_code;
    logic [DATA_W-1:0] wdata_lanes;
    logic [LANES-1:0]  be_lanes;
    logic [DATA_W-1:0] rd_merged;
    logic [DATA_W-1:0] addr_word;
    logic              half_done;

    bws_status_enc u_status (
        .locked (r_q.rmw),
        .code   (status_code)
    );

    bws_lane_swap #(.W(DATA_W)) u_swap_data (
        .din  (r_q.wdata),
        .swap (r_q.odd),
        .dout (wdata_lanes)
    );

    bws_lane_swap #(.W(LANES)) u_swap_stb (
        .din  (r_q.be),
        .swap (r_q.odd),
        .dout (be_lanes)
    );

    bws_read_merge #(.W(DATA_W)) u_merge (
        .held   (r_q.rdata),
        .bus    (lad_in),
        .odd    (r_q.odd),
        .upper  (port16_n),
        .merged (rd_merged)
    );

    always_comb begin
        addr_word                 = r_q.addr;
        addr_word[WORD_BIT]       = r_q.odd;
        addr_word[STAT_W-1:0]     = status_code;
    end

    // the current phase ends after this data cycle: odd word, or a wide port
    assign half_done = r_q.odd || port16_n;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.state    = ST_ADDR;
                    r_d.addr     = req_addr;
                    r_d.wdata    = req_wdata;
                    r_d.be       = req_be;
                    r_d.rmw      = req_rmw;
                    r_d.write    = req_write;
                    r_d.odd      = 1'b0;
                    r_d.page     = 1'b0;
                    r_d.wr_phase = req_write && !req_rmw;
                    r_d.rdata    = '0;
                end
            end
            ST_ADDR: begin
                r_d.state = ST_DATA;
            end
            ST_DATA: begin
                if (bus_fault) begin
                    r_d.state    = ST_ADDR;
                    r_d.odd      = 1'b0;
                    r_d.page     = 1'b0;
                    r_d.wr_phase = r_q.write && !r_q.rmw;
                    r_d.rdata    = '0;
                end else begin
                    if (!r_q.wr_phase) begin
                        r_d.rdata = rd_merged;
                    end
                    if (!half_done) begin
                        r_d.odd   = 1'b1;
                        r_d.page  = !page_ok_n;
                        r_d.state = page_ok_n ? ST_ADDR : ST_DATA;
                    end else if (r_q.rmw && !r_q.wr_phase) begin
                        r_d.odd      = 1'b0;
                        r_d.wr_phase = 1'b1;
                        r_d.state    = (!r_q.odd || r_q.page) ? ST_DATA : ST_ADDR;
                    end else begin
                        r_d.odd   = 1'b0;
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end
                end
            end
            default: begin
                r_d = REGS_RESET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        req_ready   = (r_q.state == ST_IDLE);
        addr_strobe = (r_q.state == ST_ADDR);
        col_stb     = (r_q.state == ST_DATA) ? be_lanes : '0;
        lad_oe      = addr_strobe || ((r_q.state == ST_DATA) && r_q.wr_phase);
        if (addr_strobe) begin
            lad_out = addr_word;
        end else if ((r_q.state == ST_DATA) && r_q.wr_phase) begin
            lad_out = wdata_lanes;
        end else begin
            lad_out = '0;
        end
        rsp_done  = r_q.done;
        rsp_rdata = r_q.done ? r_q.rdata : '0;
    end
endmodule

// File: rtl/bws_checker.sv
module bws_checker #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              addr_strobe,
    input logic [LANES-1:0]  col_stb,
    input logic [DATA_W-1:0] lad_out,
    input logic              bus_fault,
    input logic              rsp_done
);
    assert_status_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |-> (lad_out[3:0] == 4'b1000 || lad_out[3:0] == 4'b1100));

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |-> (col_stb == '0));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!addr_strobe && col_stb == '0));

    assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> addr_strobe);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_fault_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_fault && col_stb != '0) |=> (addr_strobe && !rsp_done && !lad_out[4]));
endmodule

bind bus_width_seq bws_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .addr_strobe (addr_strobe),
    .col_stb     (col_stb),
    .lad_out     (lad_out),
    .bus_fault   (bus_fault),
    .rsp_done    (rsp_done)
);

// File: tb/bus_width_seq_test.sv
module bus_width_seq_test;
    localparam int W = 32;
    localparam int L = W / 8;

    typedef struct packed {
        logic [1:0]  cfg;      // 0 wide, 1 lower half, 2 upper half
        logic        page_n;
        logic        rmw;
        logic        wr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic [31:0] exp_mem;
        logic [3:0]  na;
        logic [3:0]  nd;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [0:NV-1] = '{
        '{2'd0, 1'b1, 1'b0, 1'b0, 4'hF, 32'h0000_0000, 32'h1122_3344, 32'h1122_3344, 4'd1, 4'd1},
        '{2'd1, 1'b0, 1'b0, 1'b0, 4'hF, 32'h0000_0000, 32'h1122_3344, 32'h1122_3344, 4'd1, 4'd2},
        '{2'd2, 1'b1, 1'b0, 1'b0, 4'hF, 32'h0000_0000, 32'h1122_3344, 32'h1122_3344, 4'd2, 4'd2},
        '{2'd1, 1'b1, 1'b0, 1'b1, 4'hF, 32'hAABB_CCDD, 32'h0000_0000, 32'hAABB_CCDD, 4'd2, 4'd2},
        '{2'd2, 1'b0, 1'b0, 1'b1, 4'h1, 32'hAABB_CCDD, 32'h0000_0000, 32'h1122_33DD, 4'd1, 4'd2},
        '{2'd2, 1'b0, 1'b1, 1'b0, 4'hF, 32'h5566_7788, 32'h1122_3344, 32'h5566_7788, 4'd1, 4'd4},
        '{2'd0, 1'b1, 1'b1, 1'b0, 4'hC, 32'h99AA_BBCC, 32'h1122_3344, 32'h99AA_3344, 4'd1, 4'd2},
        '{2'd1, 1'b1, 1'b1, 1'b0, 4'hF, 32'h0F0F_0F0F, 32'h1122_3344, 32'h0F0F_0F0F, 4'd4, 4'd4},
        '{2'd0, 1'b0, 1'b0, 1'b1, 4'h6, 32'hCAFE_BABE, 32'h0000_0000, 32'h11FE_BA44, 4'd1, 4'd1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [W-1:0]  req_addr = '0;
    logic          req_write = 1'b0;
    logic          req_rmw = 1'b0;
    logic [L-1:0]  req_be = '0;
    logic [W-1:0]  req_wdata = '0;
    logic          rsp_done;
    logic [W-1:0]  rsp_rdata;
    logic          addr_strobe;
    logic [L-1:0]  col_stb;
    logic [W-1:0]  lad_out;
    logic          lad_oe;
    logic [W-1:0]  lad_in;
    logic          port16_n;
    logic          page_ok_n = 1'b1;
    logic          bus_fault;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // bus model state
    logic [1:0]  cfg = 2'd0;
    logic        odd_m = 1'b0;
    logic [31:0] mem = 32'h1122_3344;
    logic        fault_arm = 1'b0;
    logic [3:0]  exp_stat = 4'b1000;
    int n_addr = 0;
    int n_data = 0;
    int n_done = 0;
    int stat_bad = 0;
    logic [3:0] stb_second = '0;

    bus_width_seq uut (.*);

    always #4 clk = ~clk;

    // port model: narrow port fills the unused half with a marker pattern
    always_comb begin
        port16_n  = (cfg == 2'd0) ? 1'b1 : (odd_m ? (cfg == 2'd2) : 1'b0);
        bus_fault = fault_arm && odd_m && (col_stb != '0);
        unique case (cfg)
            2'd1:    lad_in = {16'hDEAD, odd_m ? mem[31:16] : mem[15:0]};
            2'd2:    lad_in = {odd_m ? mem[15:0] : mem[31:16], 16'hDEAD};
            default: lad_in = mem;
        endcase
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (addr_strobe) begin
            n_addr <= n_addr + 1;
            if (lad_out[3:0] != exp_stat || lad_out[4] != odd_m) stat_bad <= stat_bad + 1;
        end
        if (rsp_done) n_done <= n_done + 1;
        if (col_stb != '0) begin
            n_data <= n_data + 1;
            if (n_data == 1) stb_second <= col_stb;
            if (bus_fault) begin
                odd_m     <= 1'b0;
                fault_arm <= 1'b0;
            end else begin
                if (lad_oe) begin
                    for (int b = 0; b < 4; b++) begin
                        if (cfg == 2'd0 && col_stb[b]) mem[8*b +: 8] <= lad_out[8*b +: 8];
                    end
                    for (int b = 0; b < 2; b++) begin
                        if (cfg == 2'd1 && col_stb[b])
                            mem[8*b + (odd_m ? 16 : 0) +: 8] <= lad_out[8*b +: 8];
                        if (cfg == 2'd2 && col_stb[b+2])
                            mem[8*b + (odd_m ? 0 : 16) +: 8] <= lad_out[8*b + 16 +: 8];
                    end
                end
                odd_m <= (cfg == 2'd0) ? 1'b0 : ~odd_m;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // runs one access; returns read data and whether data stayed zero before done
    task automatic run_access(input vec_t v, output logic [31:0] rd, output bit quiet_ok);
        int t;
        @(negedge clk);
        cfg       = v.cfg;
        page_ok_n = v.page_n;
        mem       = 32'h1122_3344;
        odd_m     = 1'b0;
        exp_stat  = v.rmw ? 4'b1100 : 4'b1000;
        n_addr    = 0;
        n_data    = 0;
        n_done    = 0;
        stat_bad  = 0;
        req_valid = 1'b1;
        req_addr  = 32'h0004_1200;
        req_write = v.wr;
        req_rmw   = v.rmw;
        req_be    = v.be;
        req_wdata = v.wdata;
        @(negedge clk);
        req_valid = 1'b0;
        quiet_ok  = 1'b1;
        t = 0;
        while (!rsp_done && t < 100) begin
            if (rsp_rdata != '0) quiet_ok = 1'b0;
            @(negedge clk);
            t++;
        end
        if (t >= 100) begin
            checks++;
            errors++;
            $display("FAIL R9 actual=timeout expected=done");
        end
        rd = rsp_rdata;
        @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (cyc > 100000) begin
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected=<100000", cyc);
                finish_run();
            end
        end
    end

    initial begin
        logic [31:0] rd;
        bit quiet;
        vec_t fv;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(req_ready == 1'b1, "R10 ready", {31'd0, req_ready}, 32'd1);
        check(addr_strobe == 1'b0 && col_stb == '0, "R10 strobes", {27'd0, addr_strobe, col_stb}, 32'd0);
        check(rsp_done == 1'b0, "R10 done", {31'd0, rsp_done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_access(VECS[i], rd, quiet);
            // R4 R7 read result (R2 wide, R4 halves, R7 old value)
            check(rd == VECS[i].exp_rd, "R4/R7 read data", rd, VECS[i].exp_rd);
            // R5 lane and strobe routing reaches the right bytes
            check(mem == VECS[i].exp_mem, "R5 memory", mem, VECS[i].exp_mem);
            // R6 R7 address cycle count
            check(n_addr == int'(VECS[i].na), "R6 address cycles", n_addr, {28'd0, VECS[i].na});
            // R2 R3 R7 data cycle count
            check(n_data == int'(VECS[i].nd), "R3 data cycles", n_data, {28'd0, VECS[i].nd});
            // R1 status code and word select
            check(stat_bad == 0, "R1 status code", stat_bad, 0);
            // R9 one done pulse
            check(n_done == 1, "R9 done pulses", n_done, 1);
            if (i == 4) begin
                // R5 odd-word strobes for be=0001 are {be[1:0],be[3:2]} = 0100
                check(stb_second == 4'b0100, "R5 odd strobes", {28'd0, stb_second}, 32'h4);
            end
        end

        // R8 fault on the odd word of a lower-half page-mode read
        fv = '{2'd1, 1'b0, 1'b0, 1'b0, 4'hF, 32'h0, 32'h1122_3344, 32'h1122_3344, 4'd2, 4'd4};
        fault_arm = 1'b1;
        run_access(fv, rd, quiet);
        check(quiet, "R8 no partial data", {31'd0, quiet}, 32'd1);
        check(n_done == 1, "R8 single completion", n_done, 1);
        check(rd == 32'h1122_3344, "R8 restarted read", rd, 32'h1122_3344);
        check(n_addr == 2, "R8 restart address cycles", n_addr, 2);
        check(n_data == 4, "R8 restart data cycles", n_data, 4);
        check(stat_bad == 0, "R1 word select after fault", stat_bad, 0);

        finish_run();
    end
endmodule